// File: doc/BRIEF.md
# Calibrated Watch Timebase Divider

This block turns a free-running 32.768 kHz oscillator clock into the timebase of a watch: a one-cycle enable each second, a one-cycle enable each minute, and a 32 Hz square wave that lets a tester observe the oscillator rate. A crystal that runs fast is corrected without trimming it. At the start of every calibration window the divider deletes a programmed number of consecutive pulses from its 8192 Hz stage. Everything after that stage then falls behind by the same number of 8192 Hz periods.

The window is one minute or two minutes, chosen by a single select pin. The removal count is a 7-bit unsigned value, so each window can remove up to 127 pulses. One removed pulse shifts the rate by roughly 2.03 ppm with a one-minute window and roughly 1.02 ppm with a two-minute window. A typical +60 ppm crystal therefore needs a count near 30 or near 59. The removal count and the select pin are static configuration and have no handshake.

The deletion shows up on the monitor wave as a single longer half-period at the start of each window. The oscillator rate can be read from the wave at any other time. Division ratios are parameters, so a simulation can use short seconds and minutes. The prescaler ratio must be at least 2, and the stage ratio must be a power of two.

Top module: `watch_cal_divider`

## Requirements
- R1: While `rst_n` is low, `sec_tick`, `min_tick` and `mon_32hz` are all low, and every counter restarts from zero when reset is released.
- R2: With a removal count of zero, `sec_tick` pulses for one cycle once every PRE_DIV*STAGE_DIV oscillator cycles (32768 by default). The first pulse comes in cycle PRE_DIV*STAGE_DIV-1 after reset release.
- R3: `min_tick` pulses in the same cycle as every SEC_PER_MIN-th `sec_tick` (60 by default) and at no other time.
- R4: At the start of each calibration window, the first N 8192 Hz enables are deleted. N is `trim_count` read as an unsigned binary number with bit 6 as the MSB and bit 0 as the LSB. Every tick in that window comes N*PRE_DIV oscillator cycles later than it would without removal.
- R5: With `period_sel` = 0 a window lasts one minute. With `period_sel` = 1 a window lasts two minutes, so no deletion happens at the odd minute boundaries counted from reset.
- R6: `mon_32hz` is the oscillator clock divided by 1024 (PRE_DIV*2^(MON_BIT+1)) with a 50 % duty cycle. It holds its level while pulses are being deleted. After reset release it first rises in cycle (N+2^MON_BIT)*PRE_DIV.
- R7: `trim_count` is sampled only when a window begins, which is the first cycle after reset release and the cycle after each window ends. A change during a window affects only the next window.
- R8: The full count of 127 is honoured, even when it exceeds the number of stage pulses in one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, 32.768 kHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_count | input | 7 | Number of 8192 Hz pulses to delete per window, bit 6 MSB |
| period_sel | input | 1 | Window length: 0 = one minute, 1 = two minutes |
| mon_32hz | output | 1 | Oscillator/1024 square wave for rate measurement |
| sec_tick | output | 1 | One-cycle enable once per second |
| min_tick | output | 1 | One-cycle enable once per minute, coincident with a second tick |

## Verification
An error in the removal counter shows up at the first `sec_tick` of the affected window, which then lands a whole multiple of PRE_DIV cycles away from its expected cycle. The same fault also shifts the first rise of the monitor wave within a few stage pulses of reset. A wrong window phase or a wrong point at which the count is sampled appears only one window later, as a second tick that arrives early or late after a minute boundary. The scoreboard therefore predicts the exact cycle of every tick over two or more windows. A seconds counter that wraps at the wrong value moves `min_tick` off its predicted cycle at the first minute.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int TRIM_W = 7;
  typedef logic [TRIM_W-1:0] trim_t;
  typedef enum logic {
    WIN_ONE_MIN = 1'b0,
    WIN_TWO_MIN = 1'b1
  } win_len_e;
endpackage

// File: rtl/wt_prescaler.sv
// Divides the oscillator clock down to the 8192 Hz stage enable.
module wt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic stage_en
);
  localparam int W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (phase == LAST)
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  assign stage_en = (phase == LAST);

  AST_STAGE_EN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |=> !stage_en) else $error("stage enable repeated"); // R2
endmodule

// File: rtl/wt_pulse_gate.sv
// Deletes a burst of stage enables at the start of each calibration window.
module wt_pulse_gate
  import wt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stage_en,
  input  logic  win_start,
  input  trim_t trim_count,
  output logic  kept_en
);
  trim_t owed;
  logic  first_win;
  logic  load;

  assign load    = first_win | win_start;
  assign kept_en = stage_en & (owed == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed      <= '0;
      first_win <= 1'b1;
    end else begin
      first_win <= 1'b0;
      if (load)
        owed <= trim_count;
      else if (stage_en && owed != '0)
        owed <= owed - 1'b1;
    end
  end

  AST_BURST_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && owed != '0 && !load) |=> (owed == $past(owed) - 1'b1))
    else $error("burst count did not step"); // R4
  AST_COUNT_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (owed == $past(trim_count))) else $error("count not sampled"); // R7
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_en && !load) |=> $stable(owed)) else $error("count drifted"); // R7
endmodule

// File: rtl/wt_stage_counter.sv
// Counts surviving 8192 Hz enables into seconds; taps the monitor wave.
module wt_stage_counter #(
  parameter int STAGE_DIV = 8192,
  parameter int MON_BIT   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kept_en,
  output logic sec_tick,
  output logic mon_out
);
  localparam int W = $clog2(STAGE_DIV);
  localparam logic [W-1:0] LAST = W'(STAGE_DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (kept_en)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign sec_tick = kept_en & (cnt == LAST);
  assign mon_out  = cnt[MON_BIT];

  AST_MON_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !kept_en |=> $stable(mon_out)) else $error("monitor moved"); // R6
  AST_SEC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (cnt == '0)) else $error("stage count not restarted"); // R2
endmodule

// File: rtl/wt_minute_counter.sv
// Counts seconds into minutes and marks the end of each calibration window.
module wt_minute_counter
  import wt_pkg::*;
#(
  parameter int SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic period_sel,
  output logic min_tick,
  output logic win_start
);
  localparam int W = $clog2(SEC_PER_MIN);
  localparam logic [W-1:0] LAST = W'(SEC_PER_MIN - 1);

  logic [W-1:0] secs;
  logic         odd_min;

  assign min_tick  = sec_tick & (secs == LAST);
  assign win_start = min_tick & ((period_sel == WIN_ONE_MIN) | odd_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs    <= '0;
      odd_min <= 1'b0;
    end else begin
      if (sec_tick)
        secs <= (secs == LAST) ? '0 : secs + 1'b1;
      if (min_tick)
        odd_min <= !win_start;
    end
  end

  AST_MIN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick |=> (secs == '0)) else $error("second count not restarted"); // R3
  AST_WIN_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !odd_min) else $error("window phase not cleared"); // R5
  AST_WIN_PHASE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && !win_start) |=> odd_min) else $error("window phase not set"); // R5
endmodule

// File: rtl/watch_cal_divider.sv
// Top: oscillator -> 8192 Hz stage -> pulse gate -> seconds -> minutes.
module watch_cal_divider #(
  parameter int PRE_DIV     = 4,
  parameter int STAGE_DIV   = 8192,
  parameter int MON_BIT     = 7,
  parameter int SEC_PER_MIN = 60
) (
  input  logic                      clk_osc,
  input  logic                      rst_n,
  input  logic [wt_pkg::TRIM_W-1:0] trim_count,
  input  logic                      period_sel,
  output logic                      mon_32hz,
  output logic                      sec_tick,
  output logic                      min_tick
);
  logic stage_en;
  logic kept_en;
  logic win_start;
  logic sec_w;
  logic min_w;

  wt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .stage_en (stage_en)
  );

  wt_pulse_gate u_gate (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .stage_en   (stage_en),
    .win_start  (win_start),
    .trim_count (trim_count),
    .kept_en    (kept_en)
  );

  wt_stage_counter #(.STAGE_DIV(STAGE_DIV), .MON_BIT(MON_BIT)) u_stage (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .kept_en  (kept_en),
    .sec_tick (sec_w),
    .mon_out  (mon_32hz)
  );

  wt_minute_counter #(.SEC_PER_MIN(SEC_PER_MIN)) u_min (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .sec_tick   (sec_w),
    .period_sel (period_sel),
    .min_tick   (min_w),
    .win_start  (win_start)
  );

  assign sec_tick = sec_w;
  assign min_tick = min_w;

  AST_TICKS_NEED_STAGE: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sec_tick |-> stage_en) else $error("tick off stage enable"); // R2
  AST_NO_TICK_IN_BURST: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (stage_en && !kept_en) |-> !sec_tick) else $error("tick inside burst"); // R4
endmodule

// File: tb/watch_cal_divider_test.sv
module watch_cal_divider_test;
  localparam int P  = 4;
  localparam int S  = 32;
  localparam int MB = 2;
  localparam int M  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] trim = '0;
  logic       sel = 1'b0;
  logic       mon_32hz, sec_tick, min_tick;

  always #2 clk = ~clk;

  watch_cal_divider #(.PRE_DIV(P), .STAGE_DIV(S), .MON_BIT(MB), .SEC_PER_MIN(M)) uut (
    .clk_osc    (clk),
    .rst_n      (rst_n),
    .trim_count (trim),
    .period_sel (sel),
    .mon_32hz   (mon_32hz),
    .sec_tick   (sec_tick),
    .min_tick   (min_tick)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int sec_q[$];
  int min_q[$];
  int j0 = 0;
  int mon_exp = 0;
  bit mon_wait = 1'b0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: expected tick cycles for one window of L minutes and removal T.
  task automatic plan_window(input int t, input int l);
    for (int s = 1; s <= M * l; s++) begin
      int j = j0 + t + s * S - 1;
      sec_q.push_back(j * P + P - 1);
      if (s % M == 0) min_q.push_back(j * P + P - 1);
    end
    j0 += t + S * M * l;
  endtask

  task automatic start(input int t, input bit s);
    @(posedge clk); #1;
    rst_n = 1'b0;
    trim  = 7'(t);
    sel   = s;
    sec_q.delete();
    min_q.delete();
    mon_wait = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sec_tick == 1'b0, "R1 sec_tick in reset", int'(sec_tick), 0);
    check(min_tick == 1'b0, "R1 min_tick in reset", int'(min_tick), 0);
    check(mon_32hz == 1'b0, "R1 mon_32hz in reset", int'(mon_32hz), 0);
    j0 = 0;
    mon_exp = (t + (1 << MB) - 1) * P + P;
    @(posedge clk); #1;
    mon_wait = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sec_q.size() > 0 || min_q.size() > 0) && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    check(sec_q.size() == 0, "R2 second ticks outstanding", sec_q.size(), 0);
    check(min_q.size() == 0, "R3 minute ticks outstanding", min_q.size(), 0);
    repeat (P * S / 2) @(posedge clk);
  endtask

  // Monitor: compares ticks and the first monitor rise against the queues.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sec_q.size() > 0 && cyc == sec_q[0]) begin
        check(sec_tick == 1'b1, "R2/R4 sec_tick at expected cycle", cyc, sec_q[0]);
        void'(sec_q.pop_front());
      end else if (sec_tick) begin
        check(1'b0, "R4 unexpected sec_tick", cyc, (sec_q.size() > 0) ? sec_q[0] : -1);
      end
      if (min_q.size() > 0 && cyc == min_q[0]) begin
        check(min_tick == 1'b1, "R3/R5 min_tick at expected cycle", cyc, min_q[0]);
        void'(min_q.pop_front());
      end else if (min_tick) begin
        check(1'b0, "R5 unexpected min_tick", cyc, (min_q.size() > 0) ? min_q[0] : -1);
      end
      if (mon_wait && (mon_32hz || cyc > mon_exp)) begin
        check(mon_32hz && cyc == mon_exp, "R6 first monitor rise", cyc, mon_exp);
        mon_wait = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2 R3: no removal, one-minute windows
    start(0, 1'b0);
    plan_window(0, 1);
    plan_window(0, 1);
    drain();
    // R4: burst of 5 each minute
    start(5, 1'b0);
    plan_window(5, 1);
    plan_window(5, 1);
    drain();
    // R5: two-minute windows, burst of 7 (binary 0000111)
    start(7, 1'b1);
    plan_window(7, 2);
    plan_window(7, 2);
    drain();
    // R7: count changed mid-window takes effect only in the next window
    start(5, 1'b0);
    plan_window(5, 1);
    plan_window(9, 1);
    while (cyc < 150) @(posedge clk);
    #1 trim = 7'd9;
    drain();
    // R8: full count 127 (binary 1111111) exceeds one second of stage pulses
    start(127, 1'b0);
    plan_window(127, 1);
    plan_window(127, 1);
    drain();
    // R6: monitor with a count whose MSB alone is set (binary 1000000 = 64)
    start(64, 1'b0);
    plan_window(64, 1);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule